// File: doc/BRIEF.md
# Multiframe Interrupt Status Controller

This block collects four event sources from an S/T line framer and holds them as sticky bits in a status register. Software reads that register over a simple read/write bus, and each read clears it. A companion mask register decides which status bits drive the single active-high interrupt output.

Two of the bits are formed by comparisons aligned to the multiframe:

- A Q-bit change is flagged when a newly received 4-bit Q set differs from the set received before it.
- Code-violation indications are gathered over a whole multiframe. They are folded into the status bit only when the next multiframe starts, and only while multiframing mode is 0 and transparent loopback is off.

Read data and the interrupt are combinational from the current state. All state changes take effect at the rising clock edge.

Top module: `mf_irq_status`

## Requirements
- R1: After reset, all four status bits are 0, all four mask bits are 1 and `irq` is 0.
- R2: A read of address 15h returns {4'b0, status}. A read of 16h returns {4'b0, mask}. A read of any other address returns 0. In both registers, bit 0 is start of multiframe, bit 1 is Q change, bit 2 is code violation and bit 3 is INFO 4 change.
- R3: A cycle with `rd_en` high and address 15h clears every status bit at the next edge. An event in that same cycle still leaves its bit set. A write to 15h has no effect on the status bits.
- R4: A cycle with `mf_start` high sets status bit 0 at the next edge.
- R5: A cycle with `q_valid` high and `q_bits` differing from the last loaded Q set sets status bit 1. The first `q_valid` after reset only loads the comparison set and raises no event.
- R6: Status bit 2 sets at the edge ending a cycle in which `mf_start` is high, provided two conditions hold. First, `cv_hit` must have been high in that cycle or in some cycle after the previous `mf_start`, at a time when `mf_mode`=0 and `loop_transp`=0. Second, that gate must still be open in the strobe cycle. A `cv_hit` seen with the gate closed is discarded.
- R7: A cycle with `info4_chg` high sets status bit 3 at the next edge.
- R8: A write to address 16h loads `wdata[3:0]` into the mask at the next edge. A mask bit of 1 disables that interrupt and a mask bit of 0 enables it.
- R9: `irq` equals the OR over the four bits of status AND NOT mask. It stays high until the enabled bits are cleared or masked.
- R10: A set status bit stays set until a status read or reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mf_start | input | 1 | F bit opening a multiframe sent toward the terminal |
| q_valid | input | 1 | New Q set present on `q_bits` |
| q_bits | input | 4 | Received Q set |
| cv_hit | input | 1 | Code violation seen in the current cycle |
| info4_chg | input | 1 | INFO 4 state change strobe |
| mf_mode | input | 1 | Multiframing mode; violations are reported only when 0 |
| loop_transp | input | 1 | Transparent loopback active; blocks violation reporting |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq | output | 1 | Active-high interrupt |

## Verification
Timing differs between combinational results and register updates:

- `rdata` and `irq` depend only on the current state, the address and the mask, so they are due in the same cycle.
- Every event, clear and mask write lands at the next rising edge and becomes visible one cycle after its stimulus.

The bench drives inputs after the falling edge and compares both outputs against a behavioural model shortly after. The model is advanced only after the following rising edge, so each expected value matches the cycle in which it is due. The code-violation path is checked at the strobe that closes the multiframe, not at the cycle of the hit.

// File: rtl/mf_irq_status.sv
module mf_irq_status #(
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter int          NQ        = 4,
  parameter logic [7:0]  STAT_ADDR = 8'h15,
  parameter logic [7:0]  MASK_ADDR = 8'h16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mf_start,
  input  logic          q_valid,
  input  logic [NQ-1:0] q_bits,
  input  logic          cv_hit,
  input  logic          info4_chg,
  input  logic          mf_mode,
  input  logic          loop_transp,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int NB = 4;

  logic [NB-1:0] stat, mask, set;
  logic [NQ-1:0] q_prev;
  logic          q_seen, cv_acc;

  wire cv_en    = !mf_mode && !loop_transp;
  wire stat_rd  = rd_en && addr == AW'(STAT_ADDR);
  wire mask_wr  = wr_en && addr == AW'(MASK_ADDR);
  wire cv_due   = cv_acc || (cv_hit && cv_en);

  assign set[0] = mf_start;
  assign set[1] = q_valid && q_seen && (q_bits != q_prev);
  assign set[2] = mf_start && cv_en && cv_due;
  assign set[3] = info4_chg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       stat <= '0;
    else if (stat_rd) stat <= set;
    else              stat <= stat | set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask <= '1;
    else if (mask_wr) mask <= wdata[NB-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q_prev <= '0;
      q_seen <= 1'b0;
    end else if (q_valid) begin
      q_prev <= q_bits;
      q_seen <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cv_acc <= 1'b0;
    else if (mf_start) cv_acc <= 1'b0;
    else               cv_acc <= cv_due;

  always_comb begin
    rdata = '0;
    if (addr == AW'(STAT_ADDR))      rdata[NB-1:0] = stat;
    else if (addr == AW'(MASK_ADDR)) rdata[NB-1:0] = mask;
  end

  assign irq = |(stat & ~mask);

  a_r4_som_sets: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |=> stat[0]);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !info4_chg) |=> !stat[3]);
  a_r6_cv_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((mf_mode || loop_transp) && !stat[2]) |=> !stat[2]);
  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask == $past(wdata[NB-1:0]));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1] && !stat_rd) |=> stat[1]);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NB] == '0);
  a_r5_first_q_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_seen && !stat[1]) |=> !stat[1]);
endmodule

// File: tb/mf_irq_status_test.sv
module mf_irq_status_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic mf_start = 0, q_valid = 0, cv_hit = 0, info4_chg = 0;
  logic mf_mode = 0, loop_transp = 0, rd_en = 0, wr_en = 0;
  logic [3:0] q_bits = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic irq;

  int errors = 0, checks = 0;
  bit done = 0;

  int m_st[4];
  int m_mask, m_qprev, m_qseen, m_cv;

  always #(PERIOD/2) clk = ~clk;

  mf_irq_status uut (
    .clk(clk), .rst_n(rst_n), .mf_start(mf_start), .q_valid(q_valid),
    .q_bits(q_bits), .cv_hit(cv_hit), .info4_chg(info4_chg),
    .mf_mode(mf_mode), .loop_transp(loop_transp), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic int stat_val();
    int v = 0;
    for (int i = 0; i < 4; i++) if (m_st[i] != 0) v += (1 << i);
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit ms, bit qv, int qb, bit cv, bit i4,
                      bit mm, bit lt, bit rd, bit wr, int ad, int wd);
    int exp_rd, exp_irq, set_bits, en;
    @(negedge clk);
    mf_start = ms; q_valid = qv; q_bits = 4'(qb); cv_hit = cv;
    info4_chg = i4; mf_mode = mm; loop_transp = lt; rd_en = rd;
    wr_en = wr; addr = 8'(ad); wdata = 8'(wd);
    #1;
    exp_rd = (ad == 'h15) ? stat_val() : (ad == 'h16) ? m_mask : 0;
    exp_irq = ((stat_val() & ~m_mask & 'hF) != 0) ? 1 : 0;
    check({tag, " rdata (R2)"}, int'(rdata), exp_rd);
    check({tag, " irq (R9)"}, int'(irq), exp_irq);
    @(posedge clk);
    en = (!mm && !lt) ? 1 : 0;
    set_bits = 0;
    if (ms) set_bits |= 1;
    if (qv && m_qseen != 0 && qb != m_qprev) set_bits |= 2;
    if (ms && en != 0 && (m_cv != 0 || (cv && en != 0))) set_bits |= 4;
    if (i4) set_bits |= 8;
    if (rd && ad == 'h15) for (int i = 0; i < 4; i++) m_st[i] = 0;
    for (int i = 0; i < 4; i++) if (set_bits & (1 << i)) m_st[i] = 1;
    if (wr && ad == 'h16) m_mask = wd & 'hF;
    if (qv) begin m_qprev = qb; m_qseen = 1; end
    if (ms) m_cv = 0; else if (cv && en != 0) m_cv = 1;
  endtask

  task automatic idle(string tag, int ad);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, ad, 0);
  endtask

  task automatic rd_stat(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 1, 0, 'h15, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_st[i] = 0;
    m_mask = 'hF; m_qprev = 0; m_qseen = 0; m_cv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    idle("R1 reset stat", 'h15);
    idle("R1 reset mask", 'h16);
    idle("R2 other addr", 'h33);
    // R8 unmask all
    step("R8 mask write", 0, 0, 0, 0, 0, 0, 0, 0, 1, 'h16, 'hF0);
    idle("R8 mask readback", 'h16);
    // R4 start of multiframe
    step("R4 som", 1, 0, 0, 0, 0, 0, 0, 0, 0, 'h15, 0);
    idle("R4 som seen", 'h15);
    idle("R10 sticky", 'h15);
    rd_stat("R3 read clear");
    idle("R3 after clear", 'h15);
    // R5 q compare
    step("R5 first q", 0, 1, 5, 0, 0, 0, 0, 0, 0, 'h15, 0);
    idle("R5 no event first", 'h15);
    step("R5 same q", 0, 1, 5, 0, 0, 0, 0, 0, 0, 'h15, 0);
    idle("R5 no event same", 'h15);
    step("R5 new q", 0, 1, 9, 0, 0, 0, 0, 0, 0, 'h15, 0);
    idle("R5 change", 'h15);
    rd_stat("R3 clear q");
    // R6 code violation
    step("R6 hit", 0, 0, 0, 1, 0, 0, 0, 0, 0, 'h15, 0);
    idle("R6 not yet", 'h15);
    step("R6 boundary", 1, 0, 0, 0, 0, 0, 0, 0, 0, 'h15, 0);
    idle("R6 set", 'h15);
    rd_stat("R3 clear cv");
    step("R6 hit mf mode", 0, 0, 0, 1, 0, 1, 0, 0, 0, 'h15, 0);
    step("R6 boundary blocked", 1, 0, 0, 0, 0, 0, 0, 0, 0, 'h15, 0);
    idle("R6 still clear", 'h15);
    step("R6 hit loop", 0, 0, 0, 1, 0, 0, 1, 0, 0, 'h15, 0);
    step("R6 boundary loop", 1, 0, 0, 1, 0, 0, 1, 0, 0, 'h15, 0);
    idle("R6 loop clear", 'h15);
    step("R6 hit at strobe", 1, 0, 0, 1, 0, 0, 0, 0, 0, 'h15, 0);
    idle("R6 strobe hit set", 'h15);
    rd_stat("R3 clear");
    // R7 info 4
    step("R7 info4", 0, 0, 0, 0, 1, 0, 0, 0, 0, 'h15, 0);
    idle("R7 set", 'h15);
    // R8 mask single bit
    step("R8 mask bit3", 0, 0, 0, 0, 0, 0, 0, 0, 1, 'h16, 'h08);
    idle("R9 masked irq", 'h15);
    step("R8 unmask bit3", 0, 0, 0, 0, 0, 0, 0, 0, 1, 'h16, 'h07);
    idle("R9 irq back", 'h15);
    // R3 write to status ignored, collision
    step("R3 write stat", 0, 0, 0, 0, 0, 0, 0, 0, 1, 'h15, 'h00);
    idle("R3 write ignored", 'h15);
    step("R3 collide", 0, 0, 0, 0, 1, 0, 0, 1, 0, 'h15, 0);
    idle("R3 event kept", 'h15);
    rd_stat("R3 final clear");
    idle("R9 irq low", 'h15);
    idle("R2 mask read", 'h16);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule